// File: doc/BRIEF.md
# Parallel Return-to-Zero Pixel Lane Driver

This block drives a group of single-wire LED pixel chains in parallel, all sharing one bit clock. Each bit period starts with every enabled lane going high. At the short-pulse boundary, only the lanes whose data bit is 0 go low. At the long-pulse boundary, every lane goes low. One master counter marks out the bit period and raises these three shared events. A second counter walks through a pixel bit buffer, one word per bit slot. Bit n of each word is the data bit for lane n.

Software sets the timing counts, the number of slots and a lane enable mask, then pulses `start`. The block reads the buffer through a plain asynchronous read port (address out, word in). After the last slot it holds every lane low for a latch gap and then raises a single `done` pulse for the whole transfer. There are no per-bit or per-pixel events. A preset input replaces the three timing counts with built-in defaults: 125, 40 and 80 cycles, which at 100 MHz give the common 1.25 µs pixel timing. Timing that is not ordered correctly is rejected and reported with an error flag. A latch gap below the built-in minimum is raised to that minimum.

Top module: `rtz_lane_engine`

## Requirements
- R1: After reset, `lanes` is all zero and `done`, `busy` and `cfgErr` are 0.
- R2: In each bit slot, every lane enabled in the mask latched at start goes high in the first cycle of the slot. Lanes masked off stay low for the whole transfer. A lane only rises when all lanes were low in the previous cycle.
- R3: A lane whose data bit is 0 stays high for exactly `T0` cycles of its slot and then goes low.
- R4: A lane whose data bit is 1 stays high for exactly `T1` cycles. From cycle `T1` of the slot to the end of the slot, all lanes are low.
- R5: Slot s lasts `P` cycles and reads buffer word s through `rdAddr`, for s = 0, 1, … up to the slot count minus 1. Bit n of the word is lane n's bit (1 gives the long pulse).
- R6: After the last slot, lanes stay low for R = max(`cfgResetLen`, `MIN_RESET`) cycles. `done` is then high for exactly one cycle. With start sampled at edge 0, `done` is high after edge N·P+R.
- R7: `busy` is high from the edge that accepts `start` until the edge that raises `done`. A `start` that arrives while busy is ignored. When not busy, all lanes are low.
- R8: A valid start with a slot count of 0 raises `done` after the next edge. It drives no lane, never raises `busy` and leaves `cfgErr` at 0.
- R9: A start whose selected timing breaks 0 < T0 < T1 < P is rejected. `cfgErr` goes to 1, `done` pulses after the next edge and no lane moves. The next accepted start clears `cfgErr`.
- R10: With `usePreset` at 1, the timing counts come from the parameters `DEF_PERIOD`, `DEF_T0`, `DEF_T1` (defaults 125, 40, 80). The `cfg*` timing inputs are then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start strobe, one cycle |
| usePreset | input | 1 | Select the built-in timing counts |
| cfgPeriod | input | CNT_W | Bit period P in cycles |
| cfgT0h | input | CNT_W | Short-pulse high time T0 |
| cfgT1h | input | CNT_W | Long-pulse high time T1 |
| cfgResetLen | input | RST_W | Requested latch gap in cycles |
| slotCount | input | SLOT_W | Number of bit slots N |
| laneMask | input | LANES | Lane enable mask, latched at start |
| rdAddr | output | SLOT_W | Buffer read address (current slot) |
| rdData | input | LANES | Buffer word, bit n for lane n |
| lanes | output | LANES | Pixel data lines |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| cfgErr | output | 1 | Last start rejected for bad timing |

## Verification
The bench builds the block with 8 lanes, an 8-bit timing counter, 6-bit slot addressing and a minimum latch gap of 6 cycles. With these values, short custom periods of 10 to 12 cycles and requested gaps below the minimum can be run and compared cycle by cycle in a few hundred cycles. The default preset counts still fit in the 8-bit counter, so the 125/40/80 preset is exercised at its real length.

// File: rtl/rtz_pkg.sv
package rtz_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } rtz_state_e;

  // Strobes from the control FSM to the lane datapath
  typedef struct packed {
    logic latchMask;  // accepted start: capture lane enables
    logic setAll;     // slot begins: enabled lanes high, capture word
    logic clrZero;    // short boundary: zero-bit lanes low
    logic clrAll;     // long boundary: every lane low
  } rtz_strobe_t;

endpackage

// File: rtl/rtz_ctrl.sv
module rtz_ctrl
  import rtz_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SLOT_W     = 16,
  parameter int RST_W      = 16,
  parameter int MIN_RESET  = 5000,
  parameter int DEF_PERIOD = 125,
  parameter int DEF_T0     = 40,
  parameter int DEF_T1     = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              usePreset,
  input  logic [CNT_W-1:0]  cfgPeriod,
  input  logic [CNT_W-1:0]  cfgT0h,
  input  logic [CNT_W-1:0]  cfgT1h,
  input  logic [RST_W-1:0]  cfgResetLen,
  input  logic [SLOT_W-1:0] slotCount,
  output logic [SLOT_W-1:0] rdAddr,
  output rtz_strobe_t       strobe,
  output logic              busy,
  output logic              done,
  output logic              cfgErr
);

  localparam int MIN_EFF = (MIN_RESET < 1) ? 1 : MIN_RESET;
  localparam logic [RST_W-1:0] MIN_C  = RST_W'(MIN_EFF);
  localparam logic [CNT_W-1:0] DEF_P  = CNT_W'(DEF_PERIOD);
  localparam logic [CNT_W-1:0] DEF_S  = CNT_W'(DEF_T0);
  localparam logic [CNT_W-1:0] DEF_L  = CNT_W'(DEF_T1);

  rtz_state_e state;
  logic [CNT_W-1:0]  phase, period, tShort, tLong;
  logic [SLOT_W-1:0] slotIdx, nSlots;
  logic [RST_W-1:0]  gapCnt, gapLen;

  // Selected and checked configuration
  logic [CNT_W-1:0] selP, selS, selL;
  logic [RST_W-1:0] selGap;
  logic             cfgOk, accept;

  always_comb begin
    selP   = usePreset ? DEF_P : cfgPeriod;
    selS   = usePreset ? DEF_S : cfgT0h;
    selL   = usePreset ? DEF_L : cfgT1h;
    selGap = (cfgResetLen < MIN_C) ? MIN_C : cfgResetLen;
    cfgOk  = (selS != '0) && (selS < selL) && (selL < selP);
    accept = (state == ST_IDLE) && start;
  end

  always_comb begin
    strobe.latchMask = accept && cfgOk;
    strobe.setAll    = (state == ST_SEND) && (phase == '0);
    strobe.clrZero   = (state == ST_SEND) && (phase == tShort);
    strobe.clrAll    = (state == ST_SEND) && (phase == tLong);
  end

  assign rdAddr = slotIdx;
  assign busy   = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      phase   <= '0;
      slotIdx <= '0;
      gapCnt  <= '0;
      period  <= '0;
      tShort  <= '0;
      tLong   <= '0;
      nSlots  <= '0;
      gapLen  <= '0;
      done    <= 1'b0;
      cfgErr  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (!cfgOk) begin
              cfgErr <= 1'b1;
              done   <= 1'b1;
            end else begin
              cfgErr  <= 1'b0;
              period  <= selP;
              tShort  <= selS;
              tLong   <= selL;
              gapLen  <= selGap;
              nSlots  <= slotCount;
              phase   <= '0;
              slotIdx <= '0;
              if (slotCount == '0) done  <= 1'b1;
              else                 state <= ST_SEND;
            end
          end
        end
        ST_SEND: begin
          if (phase == period - CNT_W'(1)) begin
            phase <= '0;
            if (slotIdx == nSlots - SLOT_W'(1)) begin
              state  <= ST_GAP;
              gapCnt <= '0;
            end else begin
              slotIdx <= slotIdx + SLOT_W'(1);
            end
          end else begin
            phase <= phase + CNT_W'(1);
          end
        end
        ST_GAP: begin
          if (gapCnt == gapLen - RST_W'(1)) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            gapCnt <= gapCnt + RST_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rtz_lanes.sv
module rtz_lanes
  import rtz_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  rtz_strobe_t      strobe,
  input  logic [LANES-1:0] laneMask,
  input  logic [LANES-1:0] rdData,
  output logic [LANES-1:0] lanes
);

  logic [LANES-1:0] maskQ, bitQ, laneQ;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        maskQ[i] <= 1'b0;
        bitQ[i]  <= 1'b0;
        laneQ[i] <= 1'b0;
      end else begin
        if (strobe.latchMask) maskQ[i] <= laneMask[i];
        if (strobe.setAll) begin
          laneQ[i] <= maskQ[i];
          bitQ[i]  <= rdData[i];
        end else if (strobe.clrAll) begin
          laneQ[i] <= 1'b0;
        end else if (strobe.clrZero && !bitQ[i]) begin
          laneQ[i] <= 1'b0;
        end
      end
    end
  end

  assign lanes = laneQ;

endmodule

// File: rtl/rtz_lane_engine.sv
module rtz_lane_engine
  import rtz_pkg::*;
#(
  parameter int LANES      = 16,
  parameter int CNT_W      = 16,
  parameter int SLOT_W     = 16,
  parameter int RST_W      = 16,
  parameter int MIN_RESET  = 5000,
  parameter int DEF_PERIOD = 125,
  parameter int DEF_T0     = 40,
  parameter int DEF_T1     = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              usePreset,
  input  logic [CNT_W-1:0]  cfgPeriod,
  input  logic [CNT_W-1:0]  cfgT0h,
  input  logic [CNT_W-1:0]  cfgT1h,
  input  logic [RST_W-1:0]  cfgResetLen,
  input  logic [SLOT_W-1:0] slotCount,
  input  logic [LANES-1:0]  laneMask,
  output logic [SLOT_W-1:0] rdAddr,
  input  logic [LANES-1:0]  rdData,
  output logic [LANES-1:0]  lanes,
  output logic              busy,
  output logic              done,
  output logic              cfgErr
);

  rtz_strobe_t strobe;

  rtz_ctrl #(
    .CNT_W(CNT_W), .SLOT_W(SLOT_W), .RST_W(RST_W), .MIN_RESET(MIN_RESET),
    .DEF_PERIOD(DEF_PERIOD), .DEF_T0(DEF_T0), .DEF_T1(DEF_T1)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .usePreset(usePreset),
    .cfgPeriod(cfgPeriod), .cfgT0h(cfgT0h), .cfgT1h(cfgT1h),
    .cfgResetLen(cfgResetLen), .slotCount(slotCount),
    .rdAddr(rdAddr), .strobe(strobe), .busy(busy), .done(done), .cfgErr(cfgErr)
  );

  rtz_lanes #(.LANES(LANES)) u_lanes (
    .clk(clk), .rst(rst), .strobe(strobe),
    .laneMask(laneMask), .rdData(rdData), .lanes(lanes)
  );

endmodule

// File: rtl/rtz_lane_engine_chk.sv
module rtz_lane_engine_chk #(
  parameter int LANES = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic             cfgErr,
  input logic [LANES-1:0] lanes
);

  // R2: lanes rise only together, out of an all-low cycle
  assert_rise_from_low_R2: assert property (@(posedge clk) disable iff (rst)
    ((lanes & ~$past(lanes)) != '0) |-> ($past(lanes) == '0));

  // R6: completion is a single cycle with every lane low
  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (lanes == '0) ##1 !done);

  // R7: no lane activity outside a transfer
  assert_idle_lanes_low_R7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (lanes == '0));

  // R9: a rejected start never leaves a transfer running
  assert_err_idle_R9: assert property (@(posedge clk) disable iff (rst)
    cfgErr |-> !busy);

endmodule

bind rtz_lane_engine rtz_lane_engine_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .cfgErr(cfgErr), .lanes(lanes)
);

// File: tb/rtz_lane_engine_test.sv
`timescale 1ns/1ps
module rtz_lane_engine_test;

  localparam int LANES  = 8;
  localparam int CNT_W  = 8;
  localparam int SLOT_W = 6;
  localparam int RST_W  = 8;
  localparam int MINR   = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, usePreset = 1'b0;
  logic [CNT_W-1:0]  cfgPeriod = '0, cfgT0h = '0, cfgT1h = '0;
  logic [RST_W-1:0]  cfgResetLen = '0;
  logic [SLOT_W-1:0] slotCount = '0;
  logic [LANES-1:0]  laneMask = '0;
  logic [SLOT_W-1:0] rdAddr;
  logic [LANES-1:0]  rdData, lanes;
  logic busy, done, cfgErr;
  logic [LANES-1:0] mem [0:63];

  always #2 clk = ~clk;
  assign rdData = mem[rdAddr];

  rtz_lane_engine #(
    .LANES(LANES), .CNT_W(CNT_W), .SLOT_W(SLOT_W), .RST_W(RST_W), .MIN_RESET(MINR)
  ) uut (.*);

  int checks = 0, failures = 0, doneSeen = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  bit act_ = 0, expErr = 0, expDone = 0, expBusy = 0;
  int k, mN, mP, mT0, mT1, mR, selP, selS, selL;
  logic [LANES-1:0] mMask, expLanes;
  int expAddr;
  string laneTag = "R7";

  always @(posedge clk) begin
    expDone = 0;
    if (rst) begin
      act_ = 0; expErr = 0;
    end else if (act_) begin
      k++;
      if (k == mN * mP + mR) begin act_ = 0; expDone = 1; end
    end else if (start) begin
      selP = usePreset ? 125 : int'(cfgPeriod);
      selS = usePreset ? 40  : int'(cfgT0h);
      selL = usePreset ? 80  : int'(cfgT1h);
      if (!(selS > 0 && selS < selL && selL < selP)) begin
        expErr = 1; expDone = 1;
      end else begin
        expErr = 0; mP = selP; mT0 = selS; mT1 = selL;
        mR = (int'(cfgResetLen) < MINR) ? MINR : int'(cfgResetLen);
        mN = int'(slotCount); mMask = laneMask;
        if (mN == 0) expDone = 1;
        else begin act_ = 1; k = 0; end
      end
    end
    expBusy  = act_;
    expLanes = '0;
    laneTag  = act_ ? "R6" : "R7";
    expAddr  = -1;
    if (act_ && k < mN * mP) expAddr = k / mP;
    if (act_ && k >= 1 && k <= mN * mP) begin
      int s, ph;
      s = (k - 1) / mP;
      ph = (k - 1) % mP;
      laneTag = (ph < mT0) ? "R2" : (ph < mT1) ? "R3" : "R4";
      for (int i = 0; i < LANES; i++)
        expLanes[i] = mMask[i] && (ph < (mem[s][i] ? mT1 : mT0));
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(lanes == expLanes, laneTag, int'(lanes), int'(expLanes));
      chk(done == expDone, "R6", int'(done), int'(expDone));
      chk(busy == expBusy, "R7", int'(busy), int'(expBusy));
      chk(cfgErr == expErr, "R9", int'(cfgErr), int'(expErr));
      if (expAddr >= 0) chk(int'(rdAddr) == expAddr, "R5", int'(rdAddr), expAddr);
      if (done) doneSeen++;
    end
  end

  task automatic launch(input int n, input int p, input int t0, input int t1,
                        input int gap, input logic [LANES-1:0] mask, input bit pre);
    @(negedge clk);
    slotCount = SLOT_W'(n); cfgPeriod = CNT_W'(p); cfgT0h = CNT_W'(t0);
    cfgT1h = CNT_W'(t1); cfgResetLen = RST_W'(gap); laneMask = mask;
    usePreset = pre; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finishRun(input string req);
    while (act_) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(doneSeen == 1, req, doneSeen, 1);
    doneSeen = 0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = LANES'(i * 37 + 11);
    mem[0] = 8'hFF; mem[1] = 8'h00; mem[2] = 8'hA5;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(lanes == '0, "R1", int'(lanes), 0);
    chk(!done && !busy && !cfgErr, "R1", int'({done, busy, cfgErr}), 0);

    // R3 R4 R5: all lanes, mixed patterns
    launch(5, 10, 3, 7, 10, 8'hFF, 0);
    finishRun("R6");
    // R2 R6: partial mask, gap below minimum saturates to MINR
    launch(4, 12, 2, 9, 2, 8'h5A, 0);
    finishRun("R6");
    // R7: a second start while busy is ignored
    launch(3, 10, 4, 6, 8, 8'h0F, 0);
    repeat (7) @(negedge clk);
    @(negedge clk); start = 1'b1; slotCount = 6'd1; laneMask = 8'hF0;
    @(negedge clk); start = 1'b0;
    finishRun("R7");
    // R8: zero slots
    launch(0, 10, 3, 7, 8, 8'hFF, 0);
    finishRun("R8");
    chk(cfgErr == 1'b0, "R8", int'(cfgErr), 0);
    // R9: invalid timing orders
    launch(2, 10, 5, 5, 8, 8'hFF, 0);
    finishRun("R9");
    chk(cfgErr == 1'b1, "R9", int'(cfgErr), 1);
    launch(2, 10, 3, 10, 8, 8'hFF, 0);
    finishRun("R9");
    launch(2, 10, 0, 4, 8, 8'hFF, 0);
    finishRun("R9");
    launch(2, 10, 3, 7, 8, 8'h81, 0);
    finishRun("R9");
    chk(cfgErr == 1'b0, "R9", int'(cfgErr), 0);
    // R10: preset timing ignores bad cfg inputs
    launch(3, 0, 0, 0, 0, 8'hFF, 1);
    finishRun("R10");
    chk(cfgErr == 1'b0, "R10", int'(cfgErr), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule